// File: doc/BRIEF.md
# Mode-Configurable Address/GPIO Port

This block controls one 8-bit port of a microcontroller-style device. Each pin either carries a bit of the external address bus, drives a bit from a general-purpose output latch, or stays an input. The choice comes from a 3-bit operating-mode input together with a per-pin direction bit. In some modes the direction bit picks between address and input. In others it picks between the output latch and input. In a few modes the direction bit has no effect at all.

Software reaches four registers through a simple bus at fixed 16-bit addresses:
- a write-only direction register;
- an output data latch;
- a read-only view of the pin levels;
- a per-pin pull-up control register.

Several inputs decide what survives a disturbance:
- A power-on reset or hardware standby clears everything.
- A manual reset clears the data latch and the pull-up control, but the direction register keeps its value.
- In software standby, a keep-address input chooses whether address pins hold their last value or float.

Top module: `addr_gpio_port`

## Requirements
- R1: After power-on reset (`por_n` low), the direction, data and pull-up registers are 0x00 and `bus_rdata` is 0x00. With mode 3 selected, every `pin_oe` bit is 0.
- R2: A bus write (`bus_sel`=1, `bus_wr`=1) to 0xFF6B loads the data latch, and a write to 0xFF72 loads the pull-up register. A read (`bus_sel`=1, `bus_wr`=0) returns the addressed value on `bus_rdata` after the next rising edge. A cycle with no read returns 0x00. A write to any other address changes nothing.
- R3: A read of the direction register at 0xFEBB returns the fixed pattern `UNDEF_PAT`, whatever the register holds. A write to 0xFEBB loads it.
- R4: A read of 0xFF5B returns `pin_in` as it was at the clock edge of the read.
- R5: In modes 1, 4 and 5, every pin drives `addr_in` with `pin_oe` all ones, and the direction bits have no effect.
- R6: In modes 2 and 6, a pin whose direction bit is 1 drives its `addr_in` bit with `pin_oe` 1. A pin whose direction bit is 0 is an input.
- R7: In modes 3 and 7, a pin whose direction bit is 1 drives its data-latch bit with `pin_oe` 1. A pin whose direction bit is 0 is an input.
- R8: In mode 0, every pin is an input. An input pin has `pin_oe` 0 and `pin_out` 0.
- R9: While `man_rst_n` is low, the data and pull-up registers clear on each edge and bus writes are ignored. The direction register keeps its value.
- R10: While `hw_stby` is 1, `pin_oe`, `pin_out` and `pu_en` are all 0. The direction, data and pull-up registers clear on each edge.
- R11: While `sw_stby` is 1, registers keep their contents.
  - With `keep_addr`=1, address-function pins keep driving the `addr_in` value sampled at the last edge before standby.
  - With `keep_addr`=0, address-function pins get `pin_oe` 0 and `pin_out` 0.
  - Latch-driven pins keep driving.
- R12: A `pu_en` bit is 1 only when its pull-up bit is 1 and the pin's function is input. It is never 1 on a pin that has its output enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| man_rst_n | input | 1 | Manual reset, synchronous, active low |
| hw_stby | input | 1 | Hardware standby request |
| sw_stby | input | 1 | Software standby request |
| keep_addr | input | 1 | In software standby: 1 holds address pins, 0 floats them |
| mode | input | 3 | Operating mode 0..7 |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (16) | Low address bits |
| bus_wdata | input | W (8) | Write data |
| bus_rdata | output | W (8) | Registered read data |
| addr_in | input | W (8) | Address bits to be driven on the port |
| pin_in | input | W (8) | Pin levels |
| pin_out | output | W (8) | Per-pin output value |
| pin_oe | output | W (8) | Per-pin output enable |
| pu_en | output | W (8) | Per-pin pull-up enable |

## Verification
The bench keeps the default width and addresses. It overrides `UNDEF_PAT` with 0x5A. That value matches neither all-ones nor all-zeros, and none of the data or pull-up values written, so a direction read is easy to tell apart from a real register value. The default 8-bit width lets the bench split the direction bits half and half. This puts driven and input pins side by side in every mode, so each compare covers both the pull-up masking and the direction-ignored case. The 16-bit address width lets the bench write to 0xFF6C, one above the data latch, as a near-miss address.

// File: rtl/agp_pkg.sv
`timescale 1ns/1ps
package agp_pkg;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        CLS_INPUT,
        CLS_ADDR_ALL,
        CLS_ADDR_DIR,
        CLS_GPIO_DIR
    } mode_cls_e;

    typedef enum logic [1:0] {
        FN_IN,
        FN_ADDR,
        FN_GPIO
    } pin_fn_e;

    function automatic mode_cls_e classify_mode(input logic [MODE_W-1:0] m);
        case (m)
            3'd1, 3'd4, 3'd5: return CLS_ADDR_ALL;
            3'd2, 3'd6:       return CLS_ADDR_DIR;
            3'd3, 3'd7:       return CLS_GPIO_DIR;
            default:          return CLS_INPUT;
        endcase
    endfunction
endpackage

// File: rtl/agp_regs.sv
`timescale 1ns/1ps
module agp_regs #(
    parameter int W = 8,
    parameter int AW = 16,
    parameter logic [AW-1:0] DIR_ADDR = 16'hFEBB,
    parameter logic [AW-1:0] DAT_ADDR = 16'hFF6B,
    parameter logic [AW-1:0] PIN_ADDR = 16'hFF5B,
    parameter logic [AW-1:0] PUC_ADDR = 16'hFF72,
    parameter logic [W-1:0]  UNDEF_PAT = '1
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          man_rst_n,
    input  logic          hw_stby,
    input  logic          sw_stby,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    input  logic [W-1:0]  pin_in,
    input  logic [W-1:0]  addr_in,
    output logic [W-1:0]  bus_rdata,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  dat_q,
    output logic [W-1:0]  puc_q,
    output logic [W-1:0]  hold_q
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dat;
        logic [W-1:0] puc;
        logic [W-1:0] rdata;
        logic [W-1:0] hold;
    } state_t;

    state_t s_d, s_q;
    logic   wr_en_d, rd_en_d;

    always_comb begin
        s_d     = s_q;
        wr_en_d = bus_sel && bus_wr && man_rst_n && !hw_stby;
        rd_en_d = bus_sel && !bus_wr;

        // address value remembered for software standby
        if (!sw_stby) begin
            s_d.hold = addr_in;
        end

        s_d.rdata = '0;
        if (rd_en_d) begin
            case (bus_addr)
                DIR_ADDR: s_d.rdata = UNDEF_PAT;
                DAT_ADDR: s_d.rdata = s_q.dat;
                PIN_ADDR: s_d.rdata = pin_in;
                PUC_ADDR: s_d.rdata = s_q.puc;
                default:  s_d.rdata = '0;
            endcase
        end

        if (wr_en_d) begin
            case (bus_addr)
                DIR_ADDR: s_d.dir = bus_wdata;
                DAT_ADDR: s_d.dat = bus_wdata;
                PUC_ADDR: s_d.puc = bus_wdata;
                default:  ;
            endcase
        end

        // manual reset spares the direction register
        if (!man_rst_n) begin
            s_d.dat = '0;
            s_d.puc = '0;
        end

        if (hw_stby) begin
            s_d.dir = '0;
            s_d.dat = '0;
            s_d.puc = '0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata = s_q.rdata;
    assign dir_q     = s_q.dir;
    assign dat_q     = s_q.dat;
    assign puc_q     = s_q.puc;
    assign hold_q    = s_q.hold;

    assert_dir_survives_R9: assert property (@(posedge clk) disable iff (!por_n)
        (!man_rst_n && !hw_stby) |=> $stable(dir_q));

    assert_manual_clear_R9: assert property (@(posedge clk) disable iff (!por_n)
        !man_rst_n |=> (dat_q == '0) && (puc_q == '0));

    assert_hw_clear_R10: assert property (@(posedge clk) disable iff (!por_n)
        hw_stby |=> (dir_q == '0) && (dat_q == '0) && (puc_q == '0));

    assert_dir_read_pattern_R3: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel && !bus_wr && bus_addr == DIR_ADDR) |=> bus_rdata == UNDEF_PAT);

    assert_standby_keeps_regs_R11: assert property (@(posedge clk) disable iff (!por_n)
        (sw_stby && !hw_stby && man_rst_n && !bus_sel) |=> $stable(dat_q) && $stable(puc_q) && $stable(hold_q));
endmodule

// File: rtl/agp_pin_cell.sv
`timescale 1ns/1ps
module agp_pin_cell
    import agp_pkg::*;
(
    input  mode_cls_e cls,
    input  logic      dir_bit,
    input  logic      dat_bit,
    input  logic      addr_bit,
    input  logic      hold_bit,
    input  logic      puc_bit,
    input  logic      sw_stby,
    input  logic      keep_addr,
    input  logic      hw_stby,
    output logic      out_bit,
    output logic      oe_bit,
    output logic      pu_bit
);
    pin_fn_e fn_d;

    always_comb begin
        case (cls)
            CLS_ADDR_ALL: fn_d = FN_ADDR;
            CLS_ADDR_DIR: fn_d = dir_bit ? FN_ADDR : FN_IN;
            CLS_GPIO_DIR: fn_d = dir_bit ? FN_GPIO : FN_IN;
            default:      fn_d = FN_IN;
        endcase

        out_bit = 1'b0;
        oe_bit  = 1'b0;
        case (fn_d)
            FN_ADDR: begin
                if (!sw_stby) begin
                    out_bit = addr_bit;
                    oe_bit  = 1'b1;
                end else if (keep_addr) begin
                    out_bit = hold_bit;
                    oe_bit  = 1'b1;
                end
            end
            FN_GPIO: begin
                out_bit = dat_bit;
                oe_bit  = 1'b1;
            end
            default: ;
        endcase
        pu_bit = puc_bit && (fn_d == FN_IN);

        if (hw_stby) begin
            out_bit = 1'b0;
            oe_bit  = 1'b0;
            pu_bit  = 1'b0;
        end
    end
endmodule

// File: rtl/addr_gpio_port.sv
`timescale 1ns/1ps
module addr_gpio_port
    import agp_pkg::*;
#(
    parameter int W = 8,
    parameter int AW = 16,
    parameter logic [AW-1:0] DIR_ADDR = 16'hFEBB,
    parameter logic [AW-1:0] DAT_ADDR = 16'hFF6B,
    parameter logic [AW-1:0] PIN_ADDR = 16'hFF5B,
    parameter logic [AW-1:0] PUC_ADDR = 16'hFF72,
    parameter logic [W-1:0]  UNDEF_PAT = '1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              man_rst_n,
    input  logic              hw_stby,
    input  logic              sw_stby,
    input  logic              keep_addr,
    input  logic [MODE_W-1:0] mode,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      addr_in,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pu_en
);
    logic [W-1:0] dir_q, dat_q, puc_q, hold_q;
    mode_cls_e    cls_d;

    assign cls_d = classify_mode(mode);

    agp_regs #(
        .W(W), .AW(AW),
        .DIR_ADDR(DIR_ADDR), .DAT_ADDR(DAT_ADDR),
        .PIN_ADDR(PIN_ADDR), .PUC_ADDR(PUC_ADDR),
        .UNDEF_PAT(UNDEF_PAT)
    ) u_regs (
        .clk(clk), .por_n(por_n), .man_rst_n(man_rst_n),
        .hw_stby(hw_stby), .sw_stby(sw_stby),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .pin_in(pin_in), .addr_in(addr_in),
        .bus_rdata(bus_rdata), .dir_q(dir_q), .dat_q(dat_q),
        .puc_q(puc_q), .hold_q(hold_q)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        agp_pin_cell u_cell (
            .cls(cls_d), .dir_bit(dir_q[i]), .dat_bit(dat_q[i]),
            .addr_bit(addr_in[i]), .hold_bit(hold_q[i]), .puc_bit(puc_q[i]),
            .sw_stby(sw_stby), .keep_addr(keep_addr), .hw_stby(hw_stby),
            .out_bit(pin_out[i]), .oe_bit(pin_oe[i]), .pu_bit(pu_en[i])
        );
    end

    assert_hw_float_R10: assert property (@(posedge clk) disable iff (!por_n)
        hw_stby |-> (pin_oe == '0) && (pu_en == '0));

    assert_pullup_input_only_R12: assert property (@(posedge clk) disable iff (!por_n)
        (pu_en & pin_oe) == '0);

    assert_addr_modes_drive_R5: assert property (@(posedge clk) disable iff (!por_n)
        ((mode == 3'd1 || mode == 3'd4 || mode == 3'd5) && !sw_stby && !hw_stby)
        |-> (pin_oe == '1) && (pin_out == addr_in));

    assert_mode0_input_R8: assert property (@(posedge clk) disable iff (!por_n)
        (mode == 3'd0) |-> (pin_oe == '0) && (pin_out == '0));

    assert_standby_hold_R11: assert property (@(posedge clk) disable iff (!por_n)
        (sw_stby && $past(sw_stby) && keep_addr && mode == 3'd1 && $stable(mode) && !hw_stby && !$past(hw_stby))
        |-> $stable(pin_out));
endmodule

// File: tb/addr_gpio_port_bench.sv
`timescale 1ns/1ps
module addr_gpio_port_bench;
    localparam logic [7:0] UNDEF = 8'h5A;
    localparam logic [15:0] A_DIR = 16'hFEBB, A_DAT = 16'hFF6B, A_PIN = 16'hFF5B, A_PUC = 16'hFF72;

    logic clk = 1'b0;
    logic por_n = 1'b1, man_rst_n = 1'b1, hw_stby = 1'b0, sw_stby = 1'b0, keep_addr = 1'b0;
    logic [2:0] mode = 3'd3;
    logic bus_sel = 1'b0, bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, addr_in = '0, pin_in = '0;
    logic [7:0] bus_rdata, pin_out, pin_oe, pu_en;

    int n_cmp = 0, n_bad = 0;
    bit run = 0, done = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    addr_gpio_port #(.UNDEF_PAT(UNDEF)) u_addr_gpio_port (
        .clk(clk), .por_n(por_n), .man_rst_n(man_rst_n), .hw_stby(hw_stby),
        .sw_stby(sw_stby), .keep_addr(keep_addr), .mode(mode),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .addr_in(addr_in),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pu_en(pu_en)
    );

    // behavioural reference
    logic [7:0] m_dir = '0, m_dat = '0, m_puc = '0, m_rd = '0, m_hold = '0, nrd;
    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_dir = '0; m_dat = '0; m_puc = '0; m_rd = '0; m_hold = '0;
        end else begin
            nrd = '0;
            if (bus_sel && !bus_wr) begin
                if (bus_addr == A_DIR) nrd = UNDEF;
                else if (bus_addr == A_DAT) nrd = m_dat;
                else if (bus_addr == A_PIN) nrd = pin_in;
                else if (bus_addr == A_PUC) nrd = m_puc;
            end
            if (bus_sel && bus_wr && man_rst_n && !hw_stby) begin
                if (bus_addr == A_DIR) m_dir = bus_wdata;
                else if (bus_addr == A_DAT) m_dat = bus_wdata;
                else if (bus_addr == A_PUC) m_puc = bus_wdata;
            end
            if (!man_rst_n) begin m_dat = '0; m_puc = '0; end
            if (hw_stby) begin m_dir = '0; m_dat = '0; m_puc = '0; end
            if (!sw_stby) m_hold = addr_in;
            m_rd = nrd;
        end
    end

    function automatic void expect_pins(output logic [7:0] eo, output logic [7:0] eoe, output logic [7:0] epu);
        int kind; // 0 input, 1 address, 2 latch
        eo = '0; eoe = '0; epu = '0;
        for (int i = 0; i < 8; i++) begin
            case (mode)
                3'd1, 3'd4, 3'd5: kind = 1;
                3'd2, 3'd6:       kind = m_dir[i] ? 1 : 0;
                3'd3, 3'd7:       kind = m_dir[i] ? 2 : 0;
                default:          kind = 0;
            endcase
            if (hw_stby) kind = -1;
            if (kind == 1) begin
                if (!sw_stby) begin eo[i] = addr_in[i]; eoe[i] = 1'b1; end
                else if (keep_addr) begin eo[i] = m_hold[i]; eoe[i] = 1'b1; end
            end else if (kind == 2) begin
                eo[i] = m_dat[i]; eoe[i] = 1'b1;
            end else if (kind == 0) begin
                epu[i] = m_puc[i];
            end
        end
    endfunction

    task automatic chk(string name, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, name, act, exp);
        end
    endtask

    logic [7:0] eo, eoe, epu;
    always @(negedge clk) begin
        if (run && !done) begin
            expect_pins(eo, eoe, epu);
            chk("pin_out", pin_out, eo);
            chk("pin_oe", pin_oe, eoe);
            chk("pu_en", pu_en, epu);
            chk("bus_rdata", bus_rdata, m_rd);
        end
    end

    task automatic cyc(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        cyc(1);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [15:0] a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        cyc(1);
        bus_sel = 1'b0;
        cyc(1);
    endtask

    initial begin
        #1 por_n = 1'b0;
        #2 run = 1;
        cur_req = "R1";
        cyc(3);
        por_n = 1'b1;
        cyc(2);

        cur_req = "R2";
        wr(A_DAT, 8'h3C); wr(A_PUC, 8'hC3);
        rd(A_DAT); rd(A_PUC);
        wr(16'hFF6C, 8'hFF); rd(A_DAT); rd(16'hFF6C);

        cur_req = "R3";
        wr(A_DIR, 8'hF0); rd(A_DIR);

        cur_req = "R4";
        pin_in = 8'h96; rd(A_PIN);
        pin_in = 8'h69; rd(A_PIN);

        cur_req = "R7";
        mode = 3'd3; cyc(2);
        mode = 3'd7; wr(A_DAT, 8'hA5); cyc(2);

        cur_req = "R6";
        mode = 3'd2; addr_in = 8'hA5; cyc(2);
        addr_in = 8'h5A; cyc(1);
        mode = 3'd6; addr_in = 8'hC6; cyc(2);

        cur_req = "R5";
        mode = 3'd1; cyc(2);
        mode = 3'd4; addr_in = 8'h3B; cyc(1);
        mode = 3'd5; wr(A_DIR, 8'h00); cyc(2);
        wr(A_DIR, 8'h0F);

        cur_req = "R8";
        mode = 3'd0; cyc(3);

        cur_req = "R12";
        wr(A_PUC, 8'hFF); mode = 3'd2; cyc(2); mode = 3'd3; cyc(2);

        cur_req = "R9";
        wr(A_DAT, 8'h77);
        man_rst_n = 1'b0; cyc(1);
        wr(A_DIR, 8'hAA); wr(A_DAT, 8'h11);
        man_rst_n = 1'b1;
        mode = 3'd2; cyc(2); rd(A_DAT); rd(A_PUC);

        cur_req = "R11";
        wr(A_DAT, 8'hF0);
        mode = 3'd1; keep_addr = 1'b1; addr_in = 8'h11; cyc(1);
        sw_stby = 1'b1; addr_in = 8'h77; cyc(3);
        keep_addr = 1'b0; cyc(2);
        mode = 3'd3; cyc(2);
        keep_addr = 1'b1; mode = 3'd6; cyc(2);
        sw_stby = 1'b0; cyc(2);

        cur_req = "R10";
        wr(A_DIR, 8'hFF); wr(A_PUC, 8'h0F); mode = 3'd3;
        hw_stby = 1'b1; cyc(1);
        wr(A_DAT, 8'hEE); cyc(1);
        hw_stby = 1'b0; cyc(1);
        rd(A_DAT); rd(A_PUC);
        mode = 3'd2; cyc(2);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule